// File: doc/BRIEF.md
# Board Interrupt Controller Register File

This block sits on a simple synchronous register bus. It gathers sixteen external interrupt lines into one host interrupt. Each line can set a sticky bit in a pending register, but only when the matching bit of an enable register is already set. The host interrupt is raised whenever an enabled pending bit is present. Software clears a pending bit by rewriting the pending register with that bit at zero. There is no write-one-to-clear action.

Two card-slot registers report the state of a card. Interrupt line 9 belongs to slot 0 and line 13 to slot 1. Each of these lines also drives an active-low card-present bit in its slot register. Software can change only the low control bits of a slot register. Eight plain 32-bit scratch registers hold board settings such as LED patterns, switch values and miscellaneous controls.

Read data is combinational. It always shows the register selected by the current address, and a write takes effect on the rising clock edge.

Top module: `board_irq_regs`

## Requirements
- R1: After reset, every scratch register, the enable register and the pending register read 0. Both slot registers read 0x420, which is bit 10 (ready) and bit 5 (card absent). The interrupt output is 0.
- R2: The scratch registers sit at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90. Each stores a full 32-bit write, and read data shows the register at the current address.
- R3: A read from any other offset returns 0. A write to any other offset changes no register.
- R4: The enable register is at 0xC0 and the pending register at 0xD0. Both store the write data ANDed with 0x000FEEFF, so bits 8, 12 and 31:20 always read 0.
- R5: On a rising edge with no pending write, pending bit i becomes set when input i is high and enable bit i is set. The bit stays set after the input falls.
- R6: An input that is high while its enable bit is clear leaves its pending bit unchanged.
- R7: A pending write replaces the whole register, so writing 0 clears a bit. When a pending write and an input latch fall on the same edge, the write wins. The latch applies on the following edge.
- R8: The interrupt output is registered. On each edge it takes the OR of (pending AND enable) as it stood before that edge, so it lags a register change by one cycle.
- R9: Bit 5 of slot 0 (offset 0xE0) takes the inverse of input 9 on each edge. Bit 5 of slot 1 (offset 0xE4) takes the inverse of input 13.
- R10: A bus write to a slot register changes only bits 4:0. All higher bits keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address |
| irqIn | input | 16 | External interrupt lines, active high |
| irqOut | output | 1 | Combined interrupt to the host |

## Verification
The assertions check several rules on every cycle:
- pending bits are sticky unless a pending write occurs;
- no pending bit ever rises while its enable bit is clear;
- masked bit positions never hold a one;
- the interrupt output follows the previous enabled-pending state;
- the card-present bits track the inverted detect lines;
- the upper slot bits never move;
- at most one write strobe is decoded.

Only the bench scenarios can show the rest. These are the exact offset map, silent writes to unlisted offsets, full-width scratch storage, the write-wins ordering on a same-cycle collision, and the one-cycle lag of the interrupt after an enable change.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;

  localparam int NUM_SCRATCH = 8;
  localparam int SCR_IDX_W   = $clog2(NUM_SCRATCH);

  localparam logic [7:0] OFF_ENABLE  = 8'hC0;
  localparam logic [7:0] OFF_PENDING = 8'hD0;
  localparam logic [7:0] OFF_SLOT0   = 8'hE0;
  localparam logic [7:0] OFF_SLOT1   = 8'hE4;

  // Byte offsets of the plain scratch registers
  function automatic logic [7:0] scratchOff(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      default: return 8'h90;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_SCRATCH-1:0] wrScratch;
    logic                   wrEnable;
    logic                   wrPending;
    logic [1:0]             wrSlot;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SCRATCH,
    SEL_ENABLE,
    SEL_PENDING,
    SEL_SLOT0,
    SEL_SLOT1
  } rdsel_t;

endpackage

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl
  import board_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  output strobe_t              strb,
  output rdsel_t               rdSel,
  output logic [SCR_IDX_W-1:0] rdIdx
);

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    rdIdx = '0;
    for (int i = 0; i < NUM_SCRATCH; i++) begin
      if (busAddr == ADDR_W'(scratchOff(i))) begin
        rdSel             = SEL_SCRATCH;
        rdIdx             = SCR_IDX_W'(i);
        strb.wrScratch[i] = busWe;
      end
    end
    if (busAddr == ADDR_W'(OFF_ENABLE)) begin
      rdSel         = SEL_ENABLE;
      strb.wrEnable = busWe;
    end
    if (busAddr == ADDR_W'(OFF_PENDING)) begin
      rdSel          = SEL_PENDING;
      strb.wrPending = busWe;
    end
    if (busAddr == ADDR_W'(OFF_SLOT0)) begin
      rdSel          = SEL_SLOT0;
      strb.wrSlot[0] = busWe;
    end
    if (busAddr == ADDR_W'(OFF_SLOT1)) begin
      rdSel          = SEL_SLOT1;
      strb.wrSlot[1] = busWe;
    end
  end

  // R3: one address decodes to at most one register write
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R3: no write strobe without a bus write
  assert_no_idle_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (strb == '0));

endmodule

// File: rtl/board_irq_dp.sv
module board_irq_dp
  import board_irq_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter int          NUM_IRQ      = 16,
  parameter logic [31:0] IRQ_MASK     = 32'h000F_EEFF,
  parameter int          CD0_LINE     = 9,
  parameter int          CD1_LINE     = 13,
  parameter int          CD_BIT       = 5,
  parameter int          SLOT_WR_BITS = 5,
  parameter logic [31:0] SLOT_RESET   = 32'h0000_0420
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  rdsel_t               rdSel,
  input  logic [SCR_IDX_W-1:0] rdIdx,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_IRQ-1:0]   irqIn,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 irqOut
);

  localparam logic [DATA_W-1:0] maskW = DATA_W'(IRQ_MASK);

  logic [DATA_W-1:0] scratchQ [NUM_SCRATCH];
  logic [DATA_W-1:0] slotQ    [2];
  logic [DATA_W-1:0] enableQ;
  logic [DATA_W-1:0] pendingQ;
  logic [DATA_W-1:0] irqWide;

  assign irqWide = DATA_W'(irqIn);

  // Scratch storage
  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : gScratch
    always_ff @(posedge clk) begin
      if (!rstN)                 scratchQ[g] <= '0;
      else if (strb.wrScratch[g]) scratchQ[g] <= busWdata;
    end
  end

  // Enable and sticky pending
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ  <= '0;
      pendingQ <= '0;
      irqOut   <= 1'b0;
    end else begin
      if (strb.wrEnable) enableQ <= busWdata & maskW;
      if (strb.wrPending) pendingQ <= busWdata & maskW;
      else                pendingQ <= pendingQ | (irqWide & enableQ);
      irqOut <= |(pendingQ & enableQ);
    end
  end

  // Card-slot registers with detect mirror
  for (genvar g = 0; g < 2; g++) begin : gSlot
    localparam int cdLine = (g == 0) ? CD0_LINE : CD1_LINE;
    logic [DATA_W-1:0] slotNext;
    always_comb begin
      slotNext = slotQ[g];
      if (strb.wrSlot[g]) slotNext[SLOT_WR_BITS-1:0] = busWdata[SLOT_WR_BITS-1:0];
      slotNext[CD_BIT] = ~irqIn[cdLine];
    end
    always_ff @(posedge clk) begin
      if (!rstN) slotQ[g] <= DATA_W'(SLOT_RESET);
      else       slotQ[g] <= slotNext;
    end

    // R9: detect bit is the inverse of the line one edge earlier
    assert_cd_mirror_R9: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (slotQ[g][CD_BIT] == !$past(irqIn[cdLine])));

    // R10: bits above the writable field and outside the detect bit never change
    assert_slot_upper_R10: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (slotQ[g][DATA_W-1:CD_BIT+1] == $past(slotQ[g][DATA_W-1:CD_BIT+1])));
  end

  // Read mux
  always_comb begin
    case (rdSel)
      SEL_SCRATCH: busRdata = scratchQ[rdIdx];
      SEL_ENABLE:  busRdata = enableQ;
      SEL_PENDING: busRdata = pendingQ;
      SEL_SLOT0:   busRdata = slotQ[0];
      SEL_SLOT1:   busRdata = slotQ[1];
      default:     busRdata = '0;
    endcase
  end

  // R5: pending bits are sticky unless software rewrites the register
  assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPending |=> ((pendingQ & $past(pendingQ)) == $past(pendingQ)));

  // R6: a bit cannot rise while its enable was clear
  assert_no_rise_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPending |=> ((pendingQ & ~$past(pendingQ) & ~$past(enableQ)) == '0));

  // R4: masked positions never hold a one
  assert_mask_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    (((pendingQ | enableQ) & ~maskW) == '0));

  // R8: output follows the previous enabled-pending state
  assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(pendingQ & enableQ))));

endmodule

// File: rtl/board_irq_regs.sv
module board_irq_regs
  import board_irq_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 32,
  parameter int          NUM_IRQ      = 16,
  parameter logic [31:0] IRQ_MASK     = 32'h000F_EEFF,
  parameter int          CD0_LINE     = 9,
  parameter int          CD1_LINE     = 13,
  parameter int          CD_BIT       = 5,
  parameter int          SLOT_WR_BITS = 5,
  parameter logic [31:0] SLOT_RESET   = 32'h0000_0420
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               irqOut
);

  strobe_t              strb;
  rdsel_t               rdSel;
  logic [SCR_IDX_W-1:0] rdIdx;

  board_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .strb(strb), .rdSel(rdSel), .rdIdx(rdIdx)
  );

  board_irq_dp #(
    .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .IRQ_MASK(IRQ_MASK),
    .CD0_LINE(CD0_LINE), .CD1_LINE(CD1_LINE), .CD_BIT(CD_BIT),
    .SLOT_WR_BITS(SLOT_WR_BITS), .SLOT_RESET(SLOT_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .rdIdx(rdIdx),
    .busWdata(busWdata), .irqIn(irqIn), .busRdata(busRdata), .irqOut(irqOut)
  );

endmodule

// File: tb/board_irq_regs_tb_top.sv
`timescale 1ns/1ps
module board_irq_regs_tb_top;

  typedef struct {
    bit          isIrq;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } chk_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqIn = '0;
  logic        irqOut;

  chk_t expQ[$];
  int   testCount = 0;
  int   failCount = 0;
  bit   finished = 1'b0;

  localparam logic [7:0] SCR_OFF [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};

  always #2.5 clk = ~clk;

  board_irq_regs dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  // Queue an expectation for the current cycle (called at a falling edge)
  task automatic checkNow(input logic [7:0] a, input logic [31:0] e, input string t);
    chk_t c;
    busAddr = a;
    busWe   = 1'b0;
    c.isIrq = 1'b0; c.addr = a; c.exp = e; c.tag = t;
    expQ.push_back(c);
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    checkNow(a, e, t);
  endtask

  task automatic irqNow(input logic e, input string t);
    chk_t c;
    c.isIrq = 1'b1; c.addr = '0; c.exp = {31'b0, e}; c.tag = t;
    expQ.push_back(c);
  endtask

  task automatic doIrq(input logic e, input string t);
    @(negedge clk);
    irqNow(e, t);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // Monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        chk_t c;
        logic [31:0] act;
        c = expQ.pop_front();
        act = c.isIrq ? {31'b0, irqOut} : busRdata;
        testCount++;
        if (act !== c.exp) begin
          failCount++;
          $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                   c.tag, c.addr, act, c.exp);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      failCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 8; i++) doRead(SCR_OFF[i], 32'h0, "R1 scratch");
    doRead(8'hC0, 32'h0, "R1 enable");
    doRead(8'hD0, 32'h0, "R1 pending");
    doRead(8'hE0, 32'h420, "R1 slot0");
    doRead(8'hE4, 32'h420, "R1 slot1");
    irqNow(1'b0, "R1 irqOut");

    // R2: full-width scratch storage
    for (int i = 0; i < 8; i++) doWrite(SCR_OFF[i], 32'hA5000000 ^ (32'h01010101 * (i + 1)));
    for (int i = 0; i < 8; i++) doRead(SCR_OFF[i], 32'hA5000000 ^ (32'h01010101 * (i + 1)), "R2 scratch");
    doWrite(8'h14, 32'hFFFF_FFFF);
    doRead(8'h14, 32'hFFFF_FFFF, "R2 all ones");

    // R3: unlisted offsets
    doWrite(8'h20, 32'h1234_5678);
    doRead(8'h20, 32'h0, "R3 read unlisted");
    doRead(8'h44, 32'h0, "R3 read unlisted 0x44");
    doWrite(8'h11, 32'hDEAD_BEEF);
    doRead(8'h10, 32'hA5000000 ^ 32'h01010101, "R3 neighbour untouched");
    doRead(8'h11, 32'h0, "R3 misaligned reads zero");

    // R4: masking on enable and pending
    doWrite(8'hC0, 32'hFFFF_FFFF);
    doRead(8'hC0, 32'h000F_EEFF, "R4 enable mask");
    doWrite(8'hD0, 32'hFFFF_FFFF);
    doRead(8'hD0, 32'h000F_EEFF, "R4 pending mask");
    doIrq(1'b1, "R8 irq on enabled pending");
    doWrite(8'hD0, 32'h0);
    doWrite(8'hC0, 32'h0);
    doIrq(1'b0, "R8 irq cleared");

    // R6: input with enable clear
    @(negedge clk); irqIn = 16'h0008;
    @(negedge clk); irqIn = 16'h0000;
    doRead(8'hD0, 32'h0, "R6 disabled input ignored");
    irqNow(1'b0, "R6 irqOut stays low");

    // R5: enabled input latches and sticks
    doWrite(8'hC0, 32'h0000_0008);
    @(negedge clk); irqIn = 16'h0008;
    @(negedge clk); irqIn = 16'h0000;
    checkNow(8'hD0, 32'h8, "R5 pending latched");
    doRead(8'hD0, 32'h8, "R5 pending sticky");
    irqNow(1'b1, "R5 irqOut raised");

    // R7: write clears; write wins over same-edge latch
    doWrite(8'hD0, 32'h0);
    doRead(8'hD0, 32'h0, "R7 clear by write");
    irqNow(1'b0, "R7 irqOut low after clear");
    @(negedge clk);
    irqIn = 16'h0008; busAddr = 8'hD0; busWdata = 32'h1; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    checkNow(8'hD0, 32'h1, "R7 write wins");
    doRead(8'hD0, 32'h9, "R7 latch next edge");
    irqIn = 16'h0000;

    // R8: output lags enable change by one cycle
    @(negedge clk);
    busAddr = 8'hC0; busWdata = 32'h0; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    irqNow(1'b1, "R8 output still high");
    doIrq(1'b0, "R8 output low one cycle later");

    // R9: card-detect mirror
    @(negedge clk); irqIn = 16'h0200;
    @(negedge clk);
    checkNow(8'hE0, 32'h400, "R9 slot0 card present");
    doRead(8'hE4, 32'h420, "R9 slot1 unaffected");
    irqIn = 16'h2000;
    @(negedge clk);
    checkNow(8'hE4, 32'h400, "R9 slot1 card present");
    doRead(8'hE0, 32'h420, "R9 slot0 card removed");
    irqIn = 16'h0000;
    doRead(8'hE4, 32'h420, "R9 slot1 card removed");

    // R10: slot writes limited to bits 4:0
    doWrite(8'hE0, 32'hFFFF_FFFF);
    doRead(8'hE0, 32'h43F, "R10 slot0 low bits only");
    doWrite(8'hE4, 32'h0);
    doRead(8'hE4, 32'h420, "R10 slot1 upper kept");
    doWrite(8'hE0, 32'h0000_0015);
    doRead(8'hE0, 32'h435, "R10 slot0 rewrite");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule